// File: doc/BRIEF.md
# Serial Clock Stretch Timeout Monitor

This block watches the serial clock line of a two-wire bus controller while that controller acts as bus master. When the master has let go of the clock line but a target keeps the line low for longer than a programmable number of serial clock periods, the transfer cannot move on. The monitor detects that stall and emits a single-cycle timeout event. The event also appears as a set-request on bit 3 of a 10-bit interrupt flag vector.

The monitor takes the synchronized clock line level and a master-active qualifier. It also takes a flag that says whether the controller itself is releasing the line, a one-cycle strobe once per serial clock period, and a load port for an 8-bit limit register. The register holds the allowed low time as a count minus one. Its value after reset is 0x1F. Bus recovery after a timeout is left to other logic.

Top module: `scl_stretch_watchdog`

## Requirements
- R1: The 8-bit limit register holds 0x1F after reset. While `cfg_load` is 1 at a rising clock edge, the register takes `cfg_value` at that edge. The new value applies from the next cycle on.
- R2: Period strobes are counted only while all three of these hold: `master_active` is 1, `scl_release` is 1, and `scl_level` is 0. This is the stretch condition. Low time that the master drives itself is never counted.
- R3: In any cycle where the stretch condition is false, the count of strobes goes back to zero. Partial low periods do not add up across a high phase.
- R4: The allowed low time is limit+1 serial clock periods. The event fires for the strobe of a stretch at which the count already reached limit+1, that is the (limit+2)-th strobe. `timeout_event` is 1 in the clock cycle right after the cycle that carried that strobe.
- R5: `timeout_event` is high for one cycle only. It fires at most once per continuous stretch. It can fire again only after the stretch condition has ended and begun again.
- R6: After firing, the count holds at its value and does not wrap. A stretch that goes on for hundreds of further strobes produces no second event.
- R7: `flag_set` is 10 bits wide. Bit 3 equals `timeout_event`, and all other bits are 0.
- R8: Without strobes, no timeout occurs, however many clock cycles the line stays low.
- R9: Suppose a lower limit is loaded during a stretch and the count already reaches the new limit+1. The event then fires for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_level | input | 1 | Synchronized level of the serial clock line |
| master_active | input | 1 | Controller is operating as an active bus master |
| scl_release | input | 1 | Controller is currently not pulling the clock line low |
| period_tick | input | 1 | One-cycle strobe, once per serial clock period |
| cfg_load | input | 1 | Load strobe for the limit register |
| cfg_value | input | 8 | New limit value (periods minus one) |
| timeout_event | output | 1 | Single-cycle stall timeout event |
| flag_set | output | 10 | Interrupt flag set vector, timeout on bit 3 |

## Verification
On every cycle, the assertions check these properties:
- The event is a single-cycle pulse.
- Each event follows a cycle that had both the stretch condition and a strobe.
- The flag vector carries at most the one timeout bit, and that bit matches the event.
- The internal count only holds, steps by one, or returns to zero, so it never wraps.

Some behaviours can only be shown by the bench's scenarios, which compare against a reference model on every clock:
- the exact strobe at which the event fires for the default limit and for loaded limits, including 0 and 255;
- the reset value of the limit;
- the loss of partial counts across high phases, master-driven low phases and idle phases;
- the absence of any event without strobes;
- the early firing after a limit is lowered during a stretch.

// File: rtl/scl_tmo_pkg.sv
package scl_tmo_pkg;
    localparam int unsigned LIMIT_W   = 8;
    localparam int unsigned CNT_W     = LIMIT_W + 1;
    localparam logic [LIMIT_W-1:0] LIMIT_RST = 8'h1F;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
        logic             evt;
    } stretch_state_t;
endpackage

// File: rtl/scl_tmo_limit_reg.sv
module scl_tmo_limit_reg
    import scl_tmo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LIMIT_W-1:0] value,
    output logic [LIMIT_W-1:0] limit
);
    logic [LIMIT_W-1:0] limit_d, limit_q;

    always_comb begin
        limit_d = limit_q;
        if (load) limit_d = value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) limit_q <= LIMIT_RST;
        else        limit_q <= limit_d;
    end

    assign limit = limit_q;
endmodule

// File: rtl/scl_tmo_stretch_cnt.sv
module scl_tmo_stretch_cnt
    import scl_tmo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stretching,
    input  logic               tick,
    input  logic [LIMIT_W-1:0] limit,
    output logic               evt,
    output logic [CNT_W-1:0]   cnt
);
    stretch_state_t st_d, st_q;
    logic [CNT_W-1:0] allowed_d;
    logic             expire_d;

    always_comb begin
        st_d      = st_q;
        allowed_d = {1'b0, limit} + CNT_W'(1);
        expire_d  = stretching && tick && !st_q.fired && (st_q.cnt >= allowed_d);
        st_d.evt  = expire_d;
        if (!stretching) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (tick && !st_q.fired) begin
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            st_d.fired = expire_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt = st_q.evt;
    assign cnt = st_q.cnt;
endmodule

// File: rtl/scl_tmo_flag_map.sv
module scl_tmo_flag_map #(
    parameter int unsigned FLAG_W = 10,
    parameter int unsigned TO_BIT = 3
) (
    input  logic              evt,
    output logic [FLAG_W-1:0] flags
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (i == TO_BIT) begin : g_to
            assign flags[i] = evt;
        end else begin : g_zero
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/scl_stretch_watchdog.sv
module scl_stretch_watchdog
    import scl_tmo_pkg::*;
#(
    parameter int unsigned FLAG_W = 10,
    parameter int unsigned TO_BIT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_level,
    input  logic               master_active,
    input  logic               scl_release,
    input  logic               period_tick,
    input  logic               cfg_load,
    input  logic [LIMIT_W-1:0] cfg_value,
    output logic               timeout_event,
    output logic [FLAG_W-1:0]  flag_set
);
    logic [LIMIT_W-1:0] limit_w;
    logic [CNT_W-1:0]   cnt_w;
    logic               stretch_w;

    assign stretch_w = master_active && scl_release && !scl_level;

    scl_tmo_limit_reg u_limit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .value (cfg_value),
        .limit (limit_w)
    );

    scl_tmo_stretch_cnt u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .stretching (stretch_w),
        .tick       (period_tick),
        .limit      (limit_w),
        .evt        (timeout_event),
        .cnt        (cnt_w)
    );

    scl_tmo_flag_map #(.FLAG_W(FLAG_W), .TO_BIT(TO_BIT)) u_flags (
        .evt   (timeout_event),
        .flags (flag_set)
    );
endmodule

// File: rtl/scl_stretch_watchdog_chk.sv
module scl_stretch_watchdog_chk
    import scl_tmo_pkg::*;
#(
    parameter int unsigned FLAG_W = 10,
    parameter int unsigned TO_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stretch,
    input logic              tick,
    input logic              evt,
    input logic [FLAG_W-1:0] flags,
    input logic [CNT_W-1:0]  cnt
);
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    // R2
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |-> $past(stretch && tick));

    // R7
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags) && (flags[TO_BIT] == evt));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1)));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stretch |=> (cnt == '0));
endmodule

bind scl_stretch_watchdog scl_stretch_watchdog_chk #(.FLAG_W(FLAG_W), .TO_BIT(TO_BIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stretch (stretch_w),
    .tick    (period_tick),
    .evt     (timeout_event),
    .flags   (flag_set),
    .cnt     (cnt_w)
);

// File: tb/scl_stretch_watchdog_tb_top.sv
module scl_stretch_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_level = 1'b1;
    logic       master_active = 1'b0;
    logic       scl_release = 1'b1;
    logic       period_tick = 1'b0;
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_value = 8'h00;
    logic       timeout_event;
    logic [9:0] flag_set;

    int total = 0;
    int bad = 0;
    int ev_seen = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int  m_lim = 31;
    int  m_cnt = 0;
    bit  m_fired = 0;
    bit  m_exp = 0;

    scl_stretch_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .scl_level(scl_level),
        .master_active(master_active), .scl_release(scl_release),
        .period_tick(period_tick), .cfg_load(cfg_load), .cfg_value(cfg_value),
        .timeout_event(timeout_event), .flag_set(flag_set)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lim = 31; m_cnt = 0; m_fired = 0; m_exp = 0;
        end else begin
            bit st;
            st = master_active && scl_release && !scl_level;
            m_exp = st && period_tick && !m_fired && (m_cnt >= m_lim + 1);
            if (!st) begin
                m_cnt = 0; m_fired = 0;
            end else if (period_tick && !m_fired) begin
                m_cnt++;
                if (m_exp) m_fired = 1;
            end
            if (cfg_load) m_lim = cfg_value;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(timeout_event == m_exp, cur_req, timeout_event, m_exp);
            // R7
            check(flag_set == (10'(m_exp) << 3), "R7", flag_set, 10'(m_exp) << 3);
            if (timeout_event) ev_seen++;
        end
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input int n, input bit tk);
        for (int i = 0; i < n; i++) begin
            period_tick = tk;
            @(negedge clk);
        end
        period_tick = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            period_tick = 1'b1;
            @(negedge clk);
            period_tick = 1'b0;
            if (gap > 0) cyc(gap, 1'b0);
        end
    endtask

    task automatic load(input int v);
        cfg_load = 1'b1; cfg_value = 8'(v);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic release_high();
        scl_level = 1'b1;
        cyc(2, 1'b0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(timeout_event == 1'b0, "R1", timeout_event, 0);
        check(flag_set == 10'd0, "R7", flag_set, 0);
        rst_n = 1'b1;
        @(negedge clk);
        master_active = 1'b1;

        // R1 default limit 0x1F: event on the 33rd strobe
        cur_req = "R1"; base = ev_seen;
        scl_level = 1'b0;
        ticks(32, 2);
        check(ev_seen == base, "R4", ev_seen - base, 0);
        ticks(1, 2);
        check(ev_seen == base + 1, "R1", ev_seen - base, 1);
        // R6 saturation: long stretch, no more events
        cur_req = "R6";
        ticks(600, 0);
        check(ev_seen == base + 1, "R6", ev_seen - base, 1);
        release_high();

        // R4 loaded limit 3: event on 5th strobe
        cur_req = "R4";
        load(3); base = ev_seen;
        scl_level = 1'b0;
        ticks(4, 0);
        cyc(1, 1'b0);
        check(ev_seen == base, "R4", ev_seen - base, 0);
        ticks(1, 1);
        check(ev_seen == base + 1, "R4", ev_seen - base, 1);
        // R5 re-arm after high
        cur_req = "R5";
        release_high();
        scl_level = 1'b0; base = ev_seen;
        ticks(5, 1);
        check(ev_seen == base + 1, "R5", ev_seen - base, 1);
        ticks(20, 1);
        check(ev_seen == base + 1, "R5", ev_seen - base, 1);
        release_high();

        // R3 partial counts do not accumulate
        cur_req = "R3"; base = ev_seen;
        for (int k = 0; k < 5; k++) begin
            scl_level = 1'b0;
            ticks(4, 1);
            release_high();
        end
        check(ev_seen == base, "R3", ev_seen - base, 0);

        // R2 master-driven low not counted
        cur_req = "R2"; base = ev_seen;
        scl_level = 1'b0; scl_release = 1'b0;
        ticks(30, 0);
        check(ev_seen == base, "R2", ev_seen - base, 0);
        scl_release = 1'b1;
        // R2 not master: not counted
        master_active = 1'b0;
        ticks(30, 0);
        check(ev_seen == base, "R2", ev_seen - base, 0);
        master_active = 1'b1;
        release_high();

        // R8 no strobes
        cur_req = "R8"; base = ev_seen;
        scl_level = 1'b0;
        cyc(500, 1'b0);
        check(ev_seen == base, "R8", ev_seen - base, 0);
        release_high();

        // R4 limit 0: event on 2nd strobe
        cur_req = "R4";
        load(0); base = ev_seen;
        scl_level = 1'b0;
        ticks(1, 1);
        check(ev_seen == base, "R4", ev_seen - base, 0);
        ticks(1, 1);
        check(ev_seen == base + 1, "R4", ev_seen - base, 1);
        release_high();

        // R9 lower the limit mid-stretch
        cur_req = "R9";
        load(100); base = ev_seen;
        scl_level = 1'b0;
        ticks(10, 0);
        load(2);
        check(ev_seen == base, "R9", ev_seen - base, 0);
        ticks(1, 1);
        check(ev_seen == base + 1, "R9", ev_seen - base, 1);
        release_high();

        // R4 limit 255: event on the 257th strobe
        cur_req = "R4";
        load(255); base = ev_seen;
        scl_level = 1'b0;
        ticks(256, 0);
        cyc(1, 1'b0);
        check(ev_seen == base, "R4", ev_seen - base, 0);
        ticks(1, 1);
        check(ev_seen == base + 1, "R4", ev_seen - base, 1);
        release_high();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule